// File: doc/BRIEF.md
# HDLC Frame Length and FCS Checker

This block sits behind a bit-level HDLC deframer. It takes one octet per accepted beat. Each beat carries markers for start of frame, end of frame, abort and misalignment. The block runs a frame check sequence (CRC-16, CRC-32 or none) over every octet of the frame. It counts the octets, including the FCS, and when the end-of-frame beat arrives it produces a status word. The status word has separate flags for FCS mismatch, bad length and abort, and carries the octet count.

Octets reach the output through a small window buffer. A frame is held back until it reaches the minimum length for the selected CRC, so a frame that is too short never shows up downstream. When FCS stripping is on, the last two or four octets of a frame are held back and then discarded. The end-of-frame marker then moves to the last payload octet. Transparent mode turns off every length and FCS check and forwards every octet as it arrives.

The octet on the end-of-frame beat belongs to the frame. The abort and misalignment markers are sampled only on that beat. Configuration is held stable for the whole of a frame.

Top module: `hdlc_fcs_checker`

## Requirements
- R1: After reset, out_valid and stat_valid are low, and they stay low until input octets arrive.
- R2: With cfg_crc_mode = 1 (CRC-16), the CRC runs LSB first with reflected polynomial 0x8408 and starts from all ones. The transmitted FCS is the complement of the register, low octet first. stat_fcs_err is 1 exactly when the register after the last octet differs from 0xF0B8.
- R3: With cfg_crc_mode = 2 (CRC-32), the same rules apply with reflected polynomial 0xEDB88320, an all-ones start, an FCS of four octets (low octet first) and a good residue of 0xDEBB20E3.
- R4: With cfg_crc_mode = 0 (no CRC), stat_fcs_err is always 0, no octets are counted as FCS, and every frame of one or more octets is long enough.
- R5: Outside transparent mode, a frame shorter than 4 octets (CRC-16) or 6 octets (CRC-32) reports stat_len_err = 1, and none of its octets are emitted. A frame of exactly that length is forwarded.
- R6: If cfg_max_off = 0 and the octet count exceeds cfg_max_len, stat_len_err is 1. A count equal to cfg_max_len is accepted. cfg_max_off = 1 removes the upper check.
- R7: stat_octets reports the frame's octet count including the FCS octets, and both length limits compare against this count.
- R8: When cfg_strip_fcs = 1 and a CRC is selected, the last 2 or 4 octets of a forwarded frame are not emitted, and out_eof marks the last payload octet. When cfg_strip_fcs = 0, every octet is emitted.
- R9: A frame whose end beat carries in_misalign reports stat_len_err = 1, unless the block is in transparent mode.
- R10: stat_abort equals the in_abort marker of the frame's end beat.
- R11: With cfg_transparent = 1, stat_fcs_err and stat_len_err are 0, nothing is stripped and no frame is dropped. Every octet is emitted in order.
- R12: Forwarded octets leave in arrival order. out_sof is set on a frame's first emitted octet and out_eof on its last.
- R13: stat_valid is high for exactly the cycle after each end-of-frame beat is accepted, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_crc_mode | input | 2 | 0 none, 1 CRC-16, 2 CRC-32, 3 treated as none |
| cfg_max_len | input | 17 | Largest accepted octet count, FCS included |
| cfg_max_off | input | 1 | 1 disables the upper length check |
| cfg_strip_fcs | input | 1 | 1 removes the FCS octets from the output |
| cfg_transparent | input | 1 | 1 bypasses all checks and stripping |
| in_valid | input | 1 | Input octet present this cycle |
| in_data | input | 8 | Input octet |
| in_sof | input | 1 | First octet of a frame |
| in_eof | input | 1 | Last octet of a frame |
| in_abort | input | 1 | Frame closed by an abort (end beat only) |
| in_misalign | input | 1 | Frame held a non-integer number of octets (end beat only) |
| out_valid | output | 1 | Output octet present |
| out_data | output | 8 | Output octet |
| out_sof | output | 1 | First emitted octet of a frame |
| out_eof | output | 1 | Last emitted octet of a frame |
| stat_valid | output | 1 | Status word present |
| stat_fcs_err | output | 1 | FCS mismatch |
| stat_len_err | output | 1 | Too short, too long or misaligned |
| stat_abort | output | 1 | Frame was aborted |
| stat_octets | output | 17 | Octet count of the frame, FCS included |

## Verification
The bench targets the length boundaries: one octet below each CRC's minimum, exactly at the minimum, exactly at the maximum and one above it, and single-octet frames. A design that counted without the FCS, or that compared with the wrong inequality, would flag good frames or pass short ones. A short frame must produce no output octets at all. A buffer that let early octets leak would put a partial frame on the output that matches nothing expected. Stripped frames are checked for the moved end marker, which a design that decided too late would already have sent on an FCS octet. Corrupted, misaligned, aborted and transparent frames are mixed at random with varying gaps between octets, so that a frame dropped or misplaced in the output order shows up.

// File: rtl/hdlc_chk_pkg.sv
package hdlc_chk_pkg;

  typedef enum logic [1:0] {
    CRC_NONE = 2'd0,
    CRC_16   = 2'd1,
    CRC_32   = 2'd2,
    CRC_RSVD = 2'd3
  } crc_sel_e;

  localparam logic [15:0] CRC16_POLY = 16'h8408;
  localparam logic [15:0] CRC16_GOOD = 16'hF0B8;
  localparam logic [31:0] CRC32_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC32_GOOD = 32'hDEBB20E3;

  // Number of trailing FCS octets for a mode
  function automatic logic [2:0] fcs_octets(crc_sel_e m);
    case (m)
      CRC_16:  return 3'd2;
      CRC_32:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // Smallest acceptable frame, FCS included
  function automatic logic [2:0] min_octets(crc_sel_e m);
    case (m)
      CRC_16:  return 3'd4;
      CRC_32:  return 3'd6;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/hdlc_chk_crc.sv
module hdlc_chk_crc #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         start,
  input  logic [7:0]   data,
  output logic [W-1:0] crc_nxt
);

  logic [W-1:0] crc_q;
  logic [W-1:0] seed;

  assign seed = start ? '1 : crc_q;

  // One octet, LSB first, reflected register
  always_comb begin
    logic [W-1:0] c;
    c = seed;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ POLY;
      else                c = c >> 1;
    end
    crc_nxt = c;
  end

  always_ff @(posedge clk) begin
    if (rst)     crc_q <= '1;
    else if (en) crc_q <= crc_nxt;
  end

endmodule

// File: rtl/hdlc_chk_len.sv
module hdlc_chk_len #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             sof,
  input  logic             eof,
  input  logic [LEN_W-1:0] max_len,
  input  logic             max_off,
  input  logic [2:0]       min_len,
  output logic [LEN_W-1:0] n_new,
  output logic             is_short,
  output logic             is_over
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] base;

  assign base     = sof ? '0 : cnt_q;
  // Saturating count so that huge frames still read as too long
  assign n_new    = (&base) ? base : base + LEN_W'(1);
  assign is_short = n_new < LEN_W'(min_len);
  assign is_over  = !max_off && (n_new > max_len);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (push) cnt_q <= eof ? '0 : n_new;
  end

endmodule

// File: rtl/hdlc_chk_buf.sv
module hdlc_chk_buf #(
  parameter int AW = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       push_sof,
  input  logic       release_en,
  input  logic       end_frame,
  input  logic       drop,
  input  logic [2:0] hold_n,
  input  logic [2:0] strip_n,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);

  localparam int             DEPTH = 1 << AW;
  localparam logic [AW-1:0]  ONE   = AW'(1);

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] sof_f;
  logic [DEPTH-1:0] eof_f;
  logic [AW-1:0]    wr_q, rel_q, rd_q, frm_q;
  logic [AW-1:0]    wr_inc, tail, keep, fstart;
  logic             have_out;

  assign wr_inc   = wr_q + ONE;
  assign tail     = wr_inc - AW'(strip_n);
  assign keep     = wr_inc - AW'(hold_n);
  assign fstart   = push_sof ? wr_q : frm_q;
  assign have_out = (rd_q != rel_q);

  // Data storage: one write port, registered read
  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
    out_data <= mem[rd_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= '0;
      rel_q     <= '0;
      rd_q      <= '0;
      frm_q     <= '0;
      sof_f     <= '0;
      eof_f     <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      if (push) begin
        sof_f[wr_q] <= push_sof;
        eof_f[wr_q] <= 1'b0;
        if (push_sof) frm_q <= wr_q;
      end
      if (end_frame) begin
        if (drop) begin
          wr_q <= fstart;
        end else begin
          wr_q             <= tail;
          rel_q            <= tail;
          eof_f[tail - ONE] <= 1'b1;
        end
      end else if (push) begin
        wr_q <= wr_inc;
        if (release_en) rel_q <= keep;
      end
      if (have_out) rd_q <= rd_q + ONE;
      out_valid <= have_out;
      out_sof   <= have_out && sof_f[rd_q];
      out_eof   <= have_out && eof_f[rd_q];
    end
  end

endmodule

// File: rtl/hdlc_fcs_checker.sv
module hdlc_fcs_checker
  import hdlc_chk_pkg::*;
#(
  parameter int LEN_W  = 17,
  parameter int BUF_AW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_crc_mode,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic             cfg_max_off,
  input  logic             cfg_strip_fcs,
  input  logic             cfg_transparent,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_abort,
  input  logic             in_misalign,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             stat_valid,
  output logic             stat_fcs_err,
  output logic             stat_len_err,
  output logic             stat_abort,
  output logic [LEN_W-1:0] stat_octets
);

  crc_sel_e         mode;
  logic [2:0]       k_oct, min_oct, hold_n, strip_n;
  logic             strip_on, end_frame, release_en;
  logic [LEN_W-1:0] n_new;
  logic             is_short, is_over;
  logic [15:0]      c16;
  logic [31:0]      c32;
  logic             fcs_bad, len_bad;

  assign mode     = crc_sel_e'(cfg_crc_mode);
  assign k_oct    = cfg_transparent ? 3'd0 : fcs_octets(mode);
  assign min_oct  = cfg_transparent ? 3'd1 : min_octets(mode);
  assign strip_on = cfg_strip_fcs && (k_oct != 3'd0);
  assign hold_n   = strip_on ? k_oct + 3'd1 : 3'd0;
  assign strip_n  = strip_on ? k_oct : 3'd0;

  assign end_frame  = in_valid && in_eof;
  assign release_en = in_valid && !is_short;

  hdlc_chk_len #(.LEN_W(LEN_W)) len_i (
    .clk(clk), .rst(rst), .push(in_valid), .sof(in_sof), .eof(in_eof),
    .max_len(cfg_max_len), .max_off(cfg_max_off), .min_len(min_oct),
    .n_new(n_new), .is_short(is_short), .is_over(is_over)
  );

  hdlc_chk_crc #(.W(16), .POLY(CRC16_POLY)) crc16_i (
    .clk(clk), .rst(rst), .en(in_valid), .start(in_sof), .data(in_data),
    .crc_nxt(c16)
  );

  hdlc_chk_crc #(.W(32), .POLY(CRC32_POLY)) crc32_i (
    .clk(clk), .rst(rst), .en(in_valid), .start(in_sof), .data(in_data),
    .crc_nxt(c32)
  );

  assign fcs_bad = !cfg_transparent &&
                   (((mode == CRC_16) && (c16 != CRC16_GOOD)) ||
                    ((mode == CRC_32) && (c32 != CRC32_GOOD)));
  assign len_bad = !cfg_transparent && (in_misalign || is_short || is_over);

  hdlc_chk_buf #(.AW(BUF_AW)) buf_i (
    .clk(clk), .rst(rst), .push(in_valid), .push_data(in_data),
    .push_sof(in_sof), .release_en(release_en), .end_frame(end_frame),
    .drop(is_short), .hold_n(hold_n), .strip_n(strip_n),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid   <= 1'b0;
      stat_fcs_err <= 1'b0;
      stat_len_err <= 1'b0;
      stat_abort   <= 1'b0;
      stat_octets  <= '0;
    end else begin
      stat_valid <= end_frame;
      if (end_frame) begin
        stat_fcs_err <= fcs_bad;
        stat_len_err <= len_bad;
        stat_abort   <= in_abort;
        stat_octets  <= n_new;
      end
    end
  end

endmodule

// File: rtl/hdlc_fcs_checker_sva.sv
module hdlc_fcs_checker_sva
  import hdlc_chk_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cfg_crc_mode,
  input logic [LEN_W-1:0] cfg_max_len,
  input logic             cfg_max_off,
  input logic             cfg_transparent,
  input logic             in_valid,
  input logic             in_eof,
  input logic             in_abort,
  input logic             in_misalign,
  input logic             out_valid,
  input logic             stat_valid,
  input logic             stat_fcs_err,
  input logic             stat_len_err,
  input logic             stat_abort,
  input logic [LEN_W-1:0] stat_octets
);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!out_valid && !stat_valid));

  a_r13_status_after_eof: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> $past(in_valid && in_eof));

  a_r13_eof_gives_status: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof) |=> stat_valid);

  a_r11_transparent_clean: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && $past(cfg_transparent)) |-> (!stat_fcs_err && !stat_len_err));

  a_r4_none_no_fcs_err: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && ($past(cfg_crc_mode) == CRC_NONE)) |-> !stat_fcs_err);

  a_r9_misalign_len: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && $past(in_misalign) && !$past(cfg_transparent)) |-> stat_len_err);

  a_r10_abort_flag: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> (stat_abort == $past(in_abort)));

  a_r6_over_len: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !$past(cfg_transparent) && !$past(cfg_max_off) &&
     (stat_octets > $past(cfg_max_len))) |-> stat_len_err);

  a_r5_short32_len: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !$past(cfg_transparent) && ($past(cfg_crc_mode) == CRC_32) &&
     (stat_octets < LEN_W'(6))) |-> stat_len_err);

  a_r7_count_nonzero: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> (stat_octets != '0));

endmodule

bind hdlc_fcs_checker hdlc_fcs_checker_sva #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_crc_mode(cfg_crc_mode), .cfg_max_len(cfg_max_len),
  .cfg_max_off(cfg_max_off), .cfg_transparent(cfg_transparent),
  .in_valid(in_valid), .in_eof(in_eof), .in_abort(in_abort),
  .in_misalign(in_misalign), .out_valid(out_valid), .stat_valid(stat_valid),
  .stat_fcs_err(stat_fcs_err), .stat_len_err(stat_len_err),
  .stat_abort(stat_abort), .stat_octets(stat_octets)
);

// File: tb/hdlc_fcs_checker_tb_top.sv
`timescale 1ns/1ps
module hdlc_fcs_checker_tb_top;

  localparam int LW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_crc_mode = 2'd0;
  logic [LW-1:0] cfg_max_len = 17'd65536;
  logic          cfg_max_off = 1'b0;
  logic          cfg_strip_fcs = 1'b0;
  logic          cfg_transparent = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_sof = 1'b0;
  logic          in_eof = 1'b0;
  logic          in_abort = 1'b0;
  logic          in_misalign = 1'b0;
  logic          out_valid, out_sof, out_eof;
  logic [7:0]    out_data;
  logic          stat_valid, stat_fcs_err, stat_len_err, stat_abort;
  logic [LW-1:0] stat_octets;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [9:0]  exp_o[$];
  string       exp_otag[$];
  logic [19:0] exp_s[$];
  string       exp_stag[$];

  always #2.5 clk = ~clk;

  hdlc_fcs_checker dut_i (
    .clk(clk), .rst(rst), .cfg_crc_mode(cfg_crc_mode), .cfg_max_len(cfg_max_len),
    .cfg_max_off(cfg_max_off), .cfg_strip_fcs(cfg_strip_fcs),
    .cfg_transparent(cfg_transparent), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_abort(in_abort),
    .in_misalign(in_misalign), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .stat_valid(stat_valid),
    .stat_fcs_err(stat_fcs_err), .stat_len_err(stat_len_err),
    .stat_abort(stat_abort), .stat_octets(stat_octets)
  );

  function automatic logic [15:0] crc16_byte(logic [15:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 16'h8408;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] crc32_byte(logic [31:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Output and status monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (out_valid) begin
        if (exp_o.size() == 0) begin
          chk("R12", "unexpected octet", {22'd0, out_sof, out_eof, out_data}, 32'hFFFFFFFF);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_o.pop_front();
          t = exp_otag.pop_front();
          chk(t, "octet {sof,eof,data}", {22'd0, out_sof, out_eof, out_data}, {22'd0, e});
        end
      end
      if (stat_valid) begin
        if (exp_s.size() == 0) begin
          chk("R13", "unexpected status", 32'd1, 32'd0);
        end else begin
          logic [19:0] s;
          string t;
          s = exp_s.pop_front();
          t = exp_stag.pop_front();
          chk(t, "status {fcs,len,abort}", {29'd0, stat_fcs_err, stat_len_err, stat_abort},
              {29'd0, s[19:17]});
          chk("R7", "octet count", {15'd0, stat_octets}, {15'd0, s[16:0]});
        end
      end
    end
  end

  // Builds one frame, queues the expected results and drives it
  task automatic send_frame(int plen, int mode, bit strip, bit tr, bit add_fcs,
                            bit corrupt, bit mis, bit ab, int gapmax, string force_tag);
    logic [7:0]  w[$];
    logic [15:0] c16, f16;
    logic [31:0] c32, f32;
    int n, k, mn, fwd, gap;
    bit short, over, fcs_bad, len_bad;
    string tg, otg;
    @(negedge clk);
    in_valid = 1'b0;
    cfg_crc_mode = 2'(mode);
    cfg_strip_fcs = strip;
    cfg_transparent = tr;
    for (int i = 0; i < plen; i++) w.push_back(8'($urandom));
    if (!tr && add_fcs && mode == 1) begin
      c16 = 16'hFFFF;
      foreach (w[i]) c16 = crc16_byte(c16, w[i]);
      f16 = ~c16;
      w.push_back(f16[7:0]); w.push_back(f16[15:8]);
    end
    if (!tr && add_fcs && mode == 2) begin
      c32 = 32'hFFFFFFFF;
      foreach (w[i]) c32 = crc32_byte(c32, w[i]);
      f32 = ~c32;
      w.push_back(f32[7:0]); w.push_back(f32[15:8]);
      w.push_back(f32[23:16]); w.push_back(f32[31:24]);
    end
    if (corrupt) begin
      int idx;
      idx = int'($urandom % w.size());
      w[idx] = w[idx] ^ (8'd1 << ($urandom % 8));
    end
    n = w.size();
    c16 = 16'hFFFF; c32 = 32'hFFFFFFFF;
    foreach (w[i]) begin
      c16 = crc16_byte(c16, w[i]);
      c32 = crc32_byte(c32, w[i]);
    end
    k  = tr ? 0 : (mode == 1 ? 2 : (mode == 2 ? 4 : 0));
    mn = tr ? 1 : (mode == 1 ? 4 : (mode == 2 ? 6 : 1));
    short   = n < mn;
    over    = !tr && !cfg_max_off && (n > int'(cfg_max_len));
    fcs_bad = !tr && ((mode == 1 && c16 != 16'hF0B8) || (mode == 2 && c32 != 32'hDEBB20E3));
    len_bad = !tr && (mis || short || over);
    if (force_tag != "")  tg = force_tag;
    else if (tr)          tg = "R11";
    else if (mis)         tg = "R9";
    else if (ab)          tg = "R10";
    else if (short)       tg = "R5";
    else if (over)        tg = "R6";
    else if (mode == 1)   tg = "R2";
    else if (mode == 2)   tg = "R3";
    else                  tg = "R4";
    otg = tr ? "R11" : ((strip && k > 0) ? "R8" : "R12");
    fwd = short ? 0 : n - ((strip && k > 0) ? k : 0);
    for (int i = 0; i < fwd; i++) begin
      exp_o.push_back({(i == 0), (i == fwd - 1), w[i]});
      exp_otag.push_back(otg);
    end
    exp_s.push_back({fcs_bad, len_bad, ab, 17'(n)});
    exp_stag.push_back(tg);
    for (int i = 0; i < n; i++) begin
      if (i != 0) @(negedge clk);
      in_valid    = 1'b1;
      in_data     = w[i];
      in_sof      = (i == 0);
      in_eof      = (i == n - 1);
      in_abort    = (i == n - 1) && ab;
      in_misalign = (i == n - 1) && mis;
      if (i != n - 1) begin
        gap = (gapmax > 0) ? int'($urandom % (gapmax + 1)) : 0;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_abort = 1'b0; in_misalign = 1'b0;
    // R13: status appears in the cycle right after the end beat
    chk("R13", "stat_valid after end beat", {31'd0, stat_valid}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    chk("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1", "stat_valid after reset", {31'd0, stat_valid}, 32'd0);

    // CRC-16 good, stripped, corrupted
    send_frame(10, 1, 0, 0, 1, 0, 0, 0, 1, "R2");
    send_frame(10, 1, 1, 0, 1, 0, 0, 0, 0, "R8");
    send_frame(12, 1, 0, 0, 1, 1, 0, 0, 2, "R2");
    // CRC-32 good, stripped, corrupted
    send_frame(9, 2, 0, 0, 1, 0, 0, 0, 0, "R3");
    send_frame(9, 2, 1, 0, 1, 0, 0, 0, 2, "R8");
    send_frame(15, 2, 0, 0, 1, 1, 0, 0, 1, "R3");
    // No CRC
    send_frame(5, 0, 1, 0, 0, 0, 0, 0, 1, "R4");
    send_frame(1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    // Minimum lengths: 3 dropped, 4 kept (CRC-16); 5 dropped, 6 kept (CRC-32)
    send_frame(3, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
    send_frame(2, 1, 1, 0, 1, 0, 0, 0, 0, "R5");
    send_frame(5, 2, 0, 0, 0, 0, 0, 0, 1, "R5");
    send_frame(2, 2, 1, 0, 1, 0, 0, 0, 0, "R5");
    send_frame(1, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
    // Maximum length 20: at limit, above it, check disabled
    cfg_max_len = 17'd20;
    send_frame(18, 1, 0, 0, 1, 0, 0, 0, 0, "R6");
    send_frame(19, 1, 0, 0, 1, 0, 0, 0, 0, "R6");
    cfg_max_off = 1'b1;
    send_frame(30, 1, 1, 0, 1, 0, 0, 0, 0, "R6");
    cfg_max_off = 1'b0;
    cfg_max_len = 17'd65536;
    // Misalignment and abort
    send_frame(8, 1, 0, 0, 1, 0, 1, 0, 1, "R9");
    send_frame(8, 2, 1, 0, 1, 0, 0, 1, 1, "R10");
    send_frame(2, 1, 0, 0, 0, 0, 0, 1, 0, "R10");
    // Transparent: short frame forwarded, strip ignored, flags clear
    send_frame(2, 2, 1, 1, 0, 0, 1, 0, 0, "R11");
    send_frame(7, 1, 1, 1, 0, 0, 0, 0, 2, "R11");

    // Random mix
    for (int f = 0; f < 60; f++) begin
      int m, pl;
      m  = int'($urandom % 3);
      pl = 1 + int'($urandom % 28);
      cfg_max_len = 17'(8 + $urandom % 30);
      cfg_max_off = ($urandom % 4) == 0;
      send_frame(pl, m, 1'($urandom), ($urandom % 6) == 0, ($urandom % 5) != 0,
                 ($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                 int'($urandom % 3), "");
    end

    repeat (60) @(negedge clk);
    chk("R12", "octets still expected", exp_o.size(), 32'd0);
    chk("R13", "status words still expected", exp_s.size(), 32'd0);
    finish_run();
  end

endmodule